// File: doc/BRIEF.md
# Ethernet Transmit Framer and Serializer

This block turns frame bytes held in a first-word-fall-through transmit FIFO into a serial bitstream, one bit for each cycle on which the bit-clock enable is high. A frame on the line is a 62-bit alternating preamble, a 2-bit start-of-frame delimiter, the frame data, and, when CRC insertion is enabled, a 32-bit frame check sequence computed over the data.

Transmission does not begin on request alone. The FIFO must already hold a configurable number of bytes, so that the byte fetch stays ahead of the line. Each data byte leaves the block least-significant bit first. The end of the frame is set by a last-byte flag that travels with the byte in the FIFO. If the FIFO runs dry while a frame is in flight, the frame is cut short and an underrun flag is raised.

Top module: `eth_tx_serializer`

## Requirements
- R1: A frame starts only from idle, on a cycle with `bitEn` high, when `txGo` is high and `fifoCount` is at least `PREFILL_BYTES` (default 4). With fewer bytes queued, `txActive` stays low however long `txGo` is held.
- R2: The line advances by exactly one bit on each clock edge where `bitEn` is high. When `bitEn` is low, `txBit` and `txActive` hold their values.
- R3: The first 62 bits of a frame alternate 1,0,1,0,… and start with 1.
- R4: The preamble is followed by two delimiter bits, both 1. The data bytes follow, each sent bit 0 first through bit 7. `fifoPop` is high for exactly one enabled cycle per byte taken, and it is never high while `fifoEmpty` is high.
- R5: The byte presented with `fifoLast` high is the final data byte of the frame. No further bytes are popped for that frame.
- R6: If `crcEnable` is high on the start cycle, the 32-bit CRC follows the last data byte. The CRC uses generator 0x04C11DB7, a register preset to all ones, and each data bit fed in transmit order. The register is shifted left, and the feedback is its bit 31 XOR the data bit. The complement of the final register is sent from bit 31 down to bit 0.
- R7: If `crcEnable` is low on the start cycle, `txActive` falls on the enabled edge right after bit 7 of the last byte.
- R8: If `fifoEmpty` is high when the next data byte is needed, the frame ends on that enabled edge. `txActive` falls, no CRC is sent, and `underrun` goes high. `underrun` stays high until the next frame starts, which clears it.
- R9: `txActive` is high for exactly the bits of the frame, from the first preamble bit through the last bit sent. `txBit` is 0 whenever `txActive` is low.
- R10: After reset, `txActive`, `txBit`, `underrun` and `fifoPop` are all 0.
- R11: Changes on `crcEnable` after the start cycle have no effect on the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Bit-clock enable; one line bit per high cycle |
| txGo | input | 1 | Request to transmit the queued frame |
| crcEnable | input | 1 | Append the CRC to the frame; sampled at start |
| fifoData | input | 8 | Byte at the FIFO head (first-word fall-through) |
| fifoLast | input | 1 | Head byte is the last byte of its frame |
| fifoEmpty | input | 1 | FIFO holds no byte |
| fifoCount | input | CNT_W | Number of bytes in the FIFO |
| fifoPop | output | 1 | Take the head byte on this clock edge |
| txBit | output | 1 | Serial line bit |
| txActive | output | 1 | Transmit enable, high while frame bits are on the line |
| underrun | output | 1 | Last frame was cut short by an empty FIFO |

## Verification
The start cycle is the first enabled edge on which `txGo` and the fill level meet R1. Line bit k is registered on the k-th enabled edge after it, counting the start edge as 0, and it holds until the next enabled edge. The bench drives `bitEn` itself, so it knows which edges are enabled. It samples on the falling edge after each one and takes one line bit only where the preceding rising edge was enabled. `txActive` falling, the underrun flag and the pop count are read on the first sample after the enabled edge that ends the frame, and the stored bit list is compared field by field with a frame built arithmetically from R3 to R7.

// File: rtl/txser_pkg.sv
package txser_pkg;

  localparam int BYTE_W   = 8;
  localparam int PRE_BITS = 62;
  localparam int SFD_BITS = 2;
  localparam int CRC_BITS = 32;
  localparam logic [CRC_BITS-1:0] CRC_POLY = 32'h04C1_1DB7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_DATA,
    ST_CRC,
    ST_DONE
  } txState_t;

  // Strobes from control to datapath, at most one line action per cycle
  typedef struct packed {
    logic crcInit;
    logic fixedEn;
    logic fixedBit;
    logic loadByte;
    logic shiftByte;
    logic shiftCrc;
    logic clearBit;
  } dpStrobe_t;

  function automatic logic [CRC_BITS-1:0] crcStep(input logic [CRC_BITS-1:0] cur,
                                                   input logic din);
    logic fb;
    fb = cur[CRC_BITS-1] ^ din;
    return {cur[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/txser_datapath.sv
module txser_datapath
  import txser_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] fifoData,
  output logic              txBit
);

  logic [BYTE_W-2:0]   shReg;
  logic [CRC_BITS-1:0] crcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBit  <= 1'b0;
      shReg  <= '0;
      crcReg <= '1;
    end else begin
      if (strobe.crcInit) begin
        crcReg <= '1;
      end
      if (strobe.clearBit) begin
        txBit <= 1'b0;
      end else if (strobe.fixedEn) begin
        txBit <= strobe.fixedBit;
      end else if (strobe.loadByte) begin
        txBit  <= fifoData[0];
        shReg  <= fifoData[BYTE_W-1:1];
        crcReg <= crcStep(crcReg, fifoData[0]);
      end else if (strobe.shiftByte) begin
        txBit  <= shReg[0];
        shReg  <= {1'b0, shReg[BYTE_W-2:1]};
        crcReg <= crcStep(crcReg, shReg[0]);
      end else if (strobe.shiftCrc) begin
        txBit  <= ~crcReg[CRC_BITS-1];
        crcReg <= {crcReg[CRC_BITS-2:0], 1'b0};
      end
    end
  end

  AST_ONE_LINE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.fixedEn, strobe.loadByte, strobe.shiftByte, strobe.shiftCrc, strobe.clearBit})); // R2

  AST_INIT_ONLY_AT_PREAMBLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.crcInit |-> (strobe.fixedEn && strobe.fixedBit)); // R6

endmodule

// File: rtl/txser_ctrl.sv
module txser_ctrl
  import txser_pkg::*;
#(
  parameter int PREFILL_BYTES = 4,
  parameter int CNT_W         = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             txGo,
  input  logic             crcEnable,
  input  logic             fifoLast,
  input  logic             fifoEmpty,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic             txBit,
  output logic             fifoPop,
  output logic             txActive,
  output logic             underrun,
  output dpStrobe_t        strobe
);

  localparam int MAX_RUN = (PRE_BITS > CRC_BITS) ? PRE_BITS : CRC_BITS;
  localparam int CW      = $clog2(MAX_RUN) + 1;
  localparam logic [CNT_W-1:0] FILL_LVL = CNT_W'(PREFILL_BYTES);
  localparam logic [CW-1:0] PRE_END  = CW'(PRE_BITS - 1);
  localparam logic [CW-1:0] SFD_END  = CW'(SFD_BITS - 1);
  localparam logic [CW-1:0] CRC_END  = CW'(CRC_BITS - 1);
  localparam logic [CW-1:0] BYTE_END = CW'(BYTE_W - 1);

  txState_t      state, nextState;
  logic [CW-1:0] cnt, nextCnt;
  logic          crcOn, nextCrcOn;
  logic          lastByte, nextLastByte;
  logic          nextActive, nextUnder;

  always_comb begin
    strobe       = '0;
    fifoPop      = 1'b0;
    nextState    = state;
    nextCnt      = cnt;
    nextCrcOn    = crcOn;
    nextLastByte = lastByte;
    nextActive   = txActive;
    nextUnder    = underrun;
    if (bitEn) begin
      unique case (state)
        ST_IDLE: begin
          if (txGo && (fifoCount >= FILL_LVL)) begin
            strobe.crcInit  = 1'b1;
            strobe.fixedEn  = 1'b1;
            strobe.fixedBit = 1'b1;
            nextState       = ST_PRE;
            nextCnt         = CW'(1);
            nextActive      = 1'b1;
            nextUnder       = 1'b0;
            nextCrcOn       = crcEnable;
            nextLastByte    = 1'b0;
          end
        end
        ST_PRE: begin
          strobe.fixedEn  = 1'b1;
          strobe.fixedBit = ~cnt[0];
          if (cnt == PRE_END) begin
            nextState = ST_SFD;
            nextCnt   = '0;
          end else begin
            nextCnt = cnt + CW'(1);
          end
        end
        ST_SFD: begin
          strobe.fixedEn  = 1'b1;
          strobe.fixedBit = 1'b1;
          if (cnt == SFD_END) begin
            nextState = ST_DATA;
            nextCnt   = '0;
          end else begin
            nextCnt = cnt + CW'(1);
          end
        end
        ST_DATA: begin
          if (cnt == '0) begin
            if (fifoEmpty) begin
              strobe.clearBit = 1'b1;
              nextActive      = 1'b0;
              nextUnder       = 1'b1;
              nextState       = ST_IDLE;
            end else begin
              strobe.loadByte = 1'b1;
              fifoPop         = 1'b1;
              nextLastByte    = fifoLast;
              nextCnt         = CW'(1);
            end
          end else begin
            strobe.shiftByte = 1'b1;
            if (cnt == BYTE_END) begin
              nextCnt = '0;
              if (lastByte) begin
                nextState = crcOn ? ST_CRC : ST_DONE;
              end
            end else begin
              nextCnt = cnt + CW'(1);
            end
          end
        end
        ST_CRC: begin
          strobe.shiftCrc = 1'b1;
          if (cnt == CRC_END) begin
            nextState = ST_DONE;
            nextCnt   = '0;
          end else begin
            nextCnt = cnt + CW'(1);
          end
        end
        ST_DONE: begin
          strobe.clearBit = 1'b1;
          nextActive      = 1'b0;
          nextState       = ST_IDLE;
        end
        default: begin
          nextState = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      crcOn    <= 1'b0;
      lastByte <= 1'b0;
      txActive <= 1'b0;
      underrun <= 1'b0;
    end else begin
      state    <= nextState;
      cnt      <= nextCnt;
      crcOn    <= nextCrcOn;
      lastByte <= nextLastByte;
      txActive <= nextActive;
      underrun <= nextUnder;
    end
  end

  AST_START_NEEDS_FILL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> ($past(fifoCount) >= FILL_LVL)); // R1

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fifoPop |-> !fifoEmpty); // R4

  AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> ($stable(txActive) && $stable(txBit))); // R2

  AST_PRE_ALTERNATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRE && $past(state) == ST_PRE && $past(bitEn)) |-> (txBit != $past(txBit))); // R3

  AST_UNDERRUN_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> !txActive); // R8

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !txActive |-> !txBit); // R9

endmodule

// File: rtl/eth_tx_serializer.sv
module eth_tx_serializer
  import txser_pkg::*;
#(
  parameter int PREFILL_BYTES = 4,
  parameter int CNT_W         = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              txGo,
  input  logic              crcEnable,
  input  logic [BYTE_W-1:0] fifoData,
  input  logic              fifoLast,
  input  logic              fifoEmpty,
  input  logic [CNT_W-1:0]  fifoCount,
  output logic              fifoPop,
  output logic              txBit,
  output logic              txActive,
  output logic              underrun
);

  dpStrobe_t strobe;

  txser_ctrl #(
    .PREFILL_BYTES (PREFILL_BYTES),
    .CNT_W         (CNT_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .bitEn     (bitEn),
    .txGo      (txGo),
    .crcEnable (crcEnable),
    .fifoLast  (fifoLast),
    .fifoEmpty (fifoEmpty),
    .fifoCount (fifoCount),
    .txBit     (txBit),
    .fifoPop   (fifoPop),
    .txActive  (txActive),
    .underrun  (underrun),
    .strobe    (strobe)
  );

  txser_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .fifoData (fifoData),
    .txBit    (txBit)
  );

endmodule

// File: tb/eth_tx_serializer_test.sv
`timescale 1ns/1ps
module eth_tx_serializer_test;

  localparam int CNT_W   = 6;
  localparam int PREFILL = 4;
  localparam real CLK_NS = 20.0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitEn = 1'b0;
  logic txGo = 1'b0;
  logic crcEnable = 1'b0;
  logic [7:0] fifoData;
  logic fifoLast, fifoEmpty;
  logic [CNT_W-1:0] fifoCount;
  logic fifoPop, txBit, txActive, underrun;

  logic [7:0] memD [32];
  logic       memL [32];
  int rd = 0;
  int wr = 0;

  assign fifoData  = memD[rd[4:0]];
  assign fifoLast  = memL[rd[4:0]];
  assign fifoEmpty = (rd == wr);
  assign fifoCount = CNT_W'(wr - rd);

  eth_tx_serializer #(.PREFILL_BYTES(PREFILL), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .txGo(txGo), .crcEnable(crcEnable),
    .fifoData(fifoData), .fifoLast(fifoLast), .fifoEmpty(fifoEmpty),
    .fifoCount(fifoCount), .fifoPop(fifoPop), .txBit(txBit),
    .txActive(txActive), .underrun(underrun)
  );

  always #(CLK_NS/2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  logic gotBits [512];
  logic expBits [512];
  int   nBits;
  int   holdErr, lowErr;
  logic startUnder;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, take the pop decision, move the
  // FIFO after the rising edge, and return on the next falling edge.
  task automatic tick(input logic en);
    logic popNow;
    bitEn = en;
    #1;
    popNow = fifoPop;
    @(posedge clk);
    #1;
    if (popNow) rd++;
    @(negedge clk);
  endtask

  function automatic logic [7:0] patByte(input int f, input int i);
    return 8'((f * 37 + i * 91 + 5) & 8'hFF);
  endfunction

  task automatic loadFifo(input int f, input int n, input bit hasLast);
    rd = 0;
    wr = n;
    for (int i = 0; i < 32; i++) begin
      memD[i] = (i < n) ? patByte(f, i) : 8'h00;
      memL[i] = hasLast && (i == n - 1);
    end
  endtask

  task automatic capture(input int gap, input bit toggleCrc, input bit baseCrc);
    int   cyc;
    bit   started, done;
    logic en, prevBit;
    cyc = 0; started = 0; done = 0; prevBit = 1'b0;
    nBits = 0; holdErr = 0; lowErr = 0; startUnder = 1'b0;
    crcEnable = baseCrc;
    txGo = 1'b1;
    while (!done && cyc < 6000) begin
      en = ((cyc % gap) == 0);
      tick(en);
      cyc++;
      if (txActive && !started) begin
        started = 1; txGo = 1'b0; startUnder = underrun;
      end
      if (started && toggleCrc) crcEnable = ~crcEnable;
      if (en) begin
        if (txActive) begin
          if (nBits < 512) gotBits[nBits] = txBit;
          nBits++;
        end else if (started) begin
          done = 1;
        end
      end else if (started && !done && (txBit !== prevBit)) begin
        holdErr++;
      end
      if (!txActive && txBit) lowErr++;
      prevBit = txBit;
    end
    txGo = 1'b0;
    crcEnable = 1'b0;
  endtask

  function automatic int buildExp(input int f, input int n, input bit withCrc);
    int k;
    logic [31:0] crc;
    logic [7:0] b;
    logic fb;
    k = 0;
    crc = 32'hFFFF_FFFF;
    for (int i = 0; i < 62; i++) begin expBits[k] = ((i % 2) == 0); k++; end
    expBits[k] = 1'b1; k++;
    expBits[k] = 1'b1; k++;
    for (int i = 0; i < n; i++) begin
      b = patByte(f, i);
      for (int j = 0; j < 8; j++) begin
        expBits[k] = b[j]; k++;
        fb = crc[31] ^ b[j];
        crc = {crc[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    end
    if (withCrc) begin
      for (int j = 31; j >= 0; j--) begin expBits[k] = ~crc[j]; k++; end
    end
    return k;
  endfunction

  function automatic int mism(input int lo, input int hi);
    int e;
    e = 0;
    for (int i = lo; i < hi; i++) if (i < 512 && gotBits[i] !== expBits[i]) e++;
    return e;
  endfunction

  task automatic runFrame(input int f, input int n, input bit crcOn, input bit hasLast,
                          input int gap, input bit toggle, input bit holdback);
    int expLen, dataEnd, sawActive;
    bit withCrc;
    loadFifo(f, n, hasLast);
    if (holdback) begin
      wr = n - 1;
      txGo = 1'b1;
      sawActive = 0;
      for (int c = 0; c < 40; c++) begin
        tick(1'b1);
        if (txActive) sawActive++;
      end
      chk(sawActive == 0, "R1", "start below fill level", sawActive, 0);
      wr = n;
    end
    withCrc = crcOn && hasLast;
    expLen  = buildExp(f, n, withCrc);
    dataEnd = 64 + 8 * n;
    capture(gap, toggle, crcOn);
    chk(startUnder == 1'b0, "R8", "underrun cleared by start", startUnder, 0);
    chk(nBits == expLen, withCrc ? "R6" : (hasLast ? "R7" : "R8"),
        "frame length", nBits, expLen);
    chk(mism(0, 62) == 0, "R3", "preamble mismatches", mism(0, 62), 0);
    chk(mism(62, 64) == 0, "R4", "delimiter mismatches", mism(62, 64), 0);
    chk(mism(64, dataEnd) == 0, "R4", "data bit mismatches", mism(64, dataEnd), 0);
    if (withCrc)
      chk(mism(dataEnd, expLen) == 0, toggle ? "R11" : "R6", "crc mismatches",
          mism(dataEnd, expLen), 0);
    chk(rd == n, "R5", "bytes popped", rd, n);
    chk(underrun == !hasLast, "R8", "underrun flag", underrun, !hasLast);
    chk(holdErr == 0, "R2", "bit changed without enable", holdErr, 0);
    chk(lowErr == 0, "R9", "line high while inactive", lowErr, 0);
    for (int c = 0; c < 3; c++) tick(1'b0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    int f;
    loadFifo(0, 0, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txActive == 1'b0, "R10", "txActive after reset", txActive, 0);
    chk(txBit == 1'b0, "R10", "txBit after reset", txBit, 0);
    chk(underrun == 1'b0, "R10", "underrun after reset", underrun, 0);
    chk(fifoPop == 1'b0, "R10", "fifoPop after reset", fifoPop, 0);

    // R1: hold below fill level, then release
    runFrame(1, 4, 1'b1, 1'b1, 1, 1'b0, 1'b1);

    // Sweep: frame lengths, CRC on/off, dense and sparse bit enables
    f = 2;
    for (int c = 0; c < 2; c++)
      for (int g = 1; g <= 3; g += 2)
        for (int n = 4; n <= 9; n++) begin
          runFrame(f, n, c[0], 1'b1, g, 1'b0, 1'b0);
          f++;
        end

    // R8 underrun, followed by a normal frame that must clear the flag
    runFrame(40, 5, 1'b1, 1'b0, 1, 1'b0, 1'b0);
    runFrame(41, 6, 1'b0, 1'b1, 2, 1'b0, 1'b0);
    runFrame(42, 4, 1'b0, 1'b0, 3, 1'b0, 1'b0);

    // R11: toggling crcEnable mid-frame, both starting values
    runFrame(50, 7, 1'b1, 1'b1, 1, 1'b1, 1'b0);
    runFrame(51, 6, 1'b0, 1'b1, 2, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule